// File: doc/BRIEF.md
# Two-Phase Micropipeline Control Chain

A clocked, cycle-level model of a bundled-data micropipeline. A parameterised number of stages sit in a line. Each stage holds a Muller C-element state bit and a data latch. Tokens move from one stage to the next by transition signalling. A toggle on a request line announces new data. A toggle on the matching acknowledge line confirms that the data was taken. Each stage waits for a request to arrive from upstream and for the downstream stage to be free, and only then captures. As a result the whole chain acts as a FIFO whose depth equals the stage count.

The matched delay that keeps bundled data ahead of its request is modelled as a fixed number of clock cycles on the request path into every stage. The two outer ports use two-phase toggles by default. A mode parameter can instead place a four-phase (return-to-zero) wrapper on both the input port and the output port.

Top module: `mp_chain`

## Requirements
- R1: While rst_ni is low, all C-element states, request toggles and acknowledge toggles are 0 and every stage is empty. After reset, req_o and ack_o are 0 and no output request appears until a new item is pushed.
- R2: A stage changes state only at a rendezvous: its delayed upstream request differs from its own state, and its downstream neighbour has taken the previous token. At the port this means req_o changes only in a cycle where req_o equals ack_i.
- R3: While the output is never acknowledged, exactly STAGES items are accepted. Any further input request stays unacknowledged until the output side releases a token, and is accepted after that.
- R4: Items leave in the order they entered. No item is lost and none is duplicated. After the chain has drained, req_o stays quiet.
- R5: In two-phase mode (MODE = HS_TWO_PHASE), each edge of req_i, rising or falling, is one item, answered by exactly one edge of ack_o. Each edge of ack_i releases exactly one output item.
- R6: In two-phase mode, on an empty chain, ack_o toggles MATCH_DLY+1 clock cycles after a req_i toggle. req_o toggles STAGES*(MATCH_DLY+1) cycles after it.
- R7: data_o is held stable while an output item is pending. A pending item means req_o differs from ack_i in two-phase mode, or req_o is high in four-phase mode.
- R8: In four-phase mode (MODE = HS_FOUR_PHASE), ack_o rises only after a high req_i has been taken into the first stage, MATCH_DLY+3 cycles after req_i rises on an empty chain. ack_o falls one cycle after req_i falls.
- R9: In four-phase mode, req_o rises only while ack_i is low. It falls one cycle after ack_i is seen high, and stays low as long as ack_i stays high.
- R10: In four-phase mode, on an empty chain, req_o rises STAGES*(MATCH_DLY+1)+2 cycles after req_i rises.
- R11: The number of items accepted but not yet released never exceeds STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Input request (toggle, or level in four-phase mode) |
| ack_o | output | 1 | Input acknowledge (toggle, or level in four-phase mode) |
| data_i | input | DATA_W | Bundled input data, held until acknowledged |
| req_o | output | 1 | Output request (toggle, or level in four-phase mode) |
| ack_i | input | 1 | Output acknowledge (toggle, or level in four-phase mode) |
| data_o | output | DATA_W | Bundled output data of the last stage |

## Verification
A C-element state bit that is flipped or stuck shows up at the ports as one of three faults: a token appears twice, a token is missing, or the chain accepts one item too many. The sequence checks see this at the next output item, and the fill test sees it at the STAGES-th input acknowledge. A wrong count of delay cycles moves the first acknowledge and the output request away from the cycle the requirements predict. A single-token latency check therefore exposes it within a few dozen cycles. A latch that captures at the wrong moment shows up as a data miscompare at the output, or as a change of data_o while a request is still pending.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic {
    HS_TWO_PHASE  = 1'b0,
    HS_FOUR_PHASE = 1'b1
  } hs_mode_e;
endpackage

// File: rtl/mp_celem.sv
module mp_celem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic c_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             c_o <= 1'b0;
    else if (a_i && b_i)     c_o <= 1'b1;
    else if (!a_i && !b_i)   c_o <= 1'b0;
  end
endmodule

// File: rtl/mp_match_dly.sv
module mp_match_dly #(
  parameter int unsigned DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned DLY_EFF = (DLY < 1) ? 1 : DLY;

  logic [DLY_EFF-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int k = 1; k < int'(DLY_EFF); k++) sr_q[k] <= sr_q[k-1];
    end
  end

  assign q_o = sr_q[DLY_EFF-1];
endmodule

// File: rtl/mp_stage.sv
module mp_stage #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MATCH_DLY = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,    // upstream toggle
  input  logic              ack_i,    // downstream state toggle
  input  logic [DATA_W-1:0] data_i,
  output logic              state_o,  // req downstream and ack upstream
  output logic [DATA_W-1:0] data_o
);
  logic req_d;
  logic capture;

  mp_match_dly #(.DLY(MATCH_DLY)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_i),
    .q_o    (req_d)
  );

  mp_celem u_celem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (req_d),
    .b_i    (~ack_i),
    .c_o    (state_o)
  );

  // latch opens on the same condition that flips the C-element
  assign capture = (req_d != state_o) && (req_d != ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (capture) data_o <= data_i;
  end
endmodule

// File: rtl/mp_hs4_in.sv
module mp_hs4_in (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req4_i,
  output logic ack4_o,
  output logic tog_o,
  input  logic ack_tog_i
);
  logic tog_q, busy_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
    end else if (!busy_q && req4_i && !ack_q) begin
      tog_q  <= ~tog_q;
      busy_q <= 1'b1;
    end else if (busy_q && (tog_q == ack_tog_i)) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b1;
    end else if (ack_q && !req4_i) begin
      ack_q  <= 1'b0;
    end
  end

  assign tog_o  = tog_q;
  assign ack4_o = ack_q;
endmodule

// File: rtl/mp_hs4_out.sv
module mp_hs4_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic ack_tog_o,
  output logic req4_o,
  input  logic ack4_i
);
  logic req_q, ack_tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      ack_tog_q <= 1'b0;
    end else if (!req_q && !ack4_i && (tog_i != ack_tog_q)) begin
      req_q     <= 1'b1;
    end else if (req_q && ack4_i) begin
      req_q     <= 1'b0;
      ack_tog_q <= ~ack_tog_q;
    end
  end

  assign req4_o    = req_q;
  assign ack_tog_o = ack_tog_q;
endmodule

// File: rtl/mp_chain.sv
module mp_chain #(
  parameter int unsigned      DATA_W    = 8,
  parameter int unsigned      STAGES    = 4,
  parameter int unsigned      MATCH_DLY = 1,
  parameter mp_pkg::hs_mode_e MODE      = mp_pkg::HS_TWO_PHASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ack_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o
);
  // tok[0]: input toggle, tok[i+1]: stage i state, tok[STAGES+1]: output ack toggle
  logic [STAGES+1:0] tok;
  logic [DATA_W-1:0] dat [STAGES+1];

  assign dat[0] = data_i;
  assign data_o = dat[STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    mp_stage #(.DATA_W(DATA_W), .MATCH_DLY(MATCH_DLY)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (tok[i]),
      .ack_i   (tok[i+2]),
      .data_i  (dat[i]),
      .state_o (tok[i+1]),
      .data_o  (dat[i+1])
    );
  end

  if (MODE == mp_pkg::HS_FOUR_PHASE) begin : g_four
    mp_hs4_in u_in (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req4_i    (req_i),
      .ack4_o    (ack_o),
      .tog_o     (tok[0]),
      .ack_tog_i (tok[1])
    );
    mp_hs4_out u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tog_i     (tok[STAGES]),
      .ack_tog_o (tok[STAGES+1]),
      .req4_o    (req_o),
      .ack4_i    (ack_i)
    );
  end else begin : g_two
    assign tok[0]        = req_i;
    assign ack_o         = tok[1];
    assign req_o         = tok[STAGES];
    assign tok[STAGES+1] = ack_i;
  end
endmodule

// File: rtl/mp_chain_chk.sv
module mp_chain_chk #(
  parameter int unsigned      DATA_W = 8,
  parameter int unsigned      STAGES = 4,
  parameter mp_pkg::hs_mode_e MODE   = mp_pkg::HS_TWO_PHASE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ack_o,
  input logic              req_o,
  input logic              ack_i,
  input logic [DATA_W-1:0] data_o
);
  logic ack_o_q, ack_i_q, in_ev, out_ev;
  int   occ;

  if (MODE == mp_pkg::HS_FOUR_PHASE) begin : g_ev4
    assign in_ev  = ack_o & ~ack_o_q;
    assign out_ev = ack_i & ~ack_i_q;
  end else begin : g_ev2
    assign in_ev  = ack_o ^ ack_o_q;
    assign out_ev = ack_i ^ ack_i_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o_q <= 1'b0;
      ack_i_q <= 1'b0;
      occ     <= 0;
    end else begin
      ack_o_q <= ack_o;
      ack_i_q <= ack_i;
      occ     <= occ + int'(in_ev) - int'(out_ev);
    end
  end

  a_r11_occ_max: assert property (@(posedge clk_i) disable iff (!rst_ni) occ <= int'(STAGES));
  a_r11_occ_min: assert property (@(posedge clk_i) disable iff (!rst_ni) occ >= 0);

  if (MODE == mp_pkg::HS_FOUR_PHASE) begin : g_a4
    a_r8_ack_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ack_o) |-> $past(req_i));
    a_r8_ack_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ack_o) |-> $past(!req_i));
    a_r9_req_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_o) |-> $past(!ack_i));
    a_r9_req_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(req_o) |-> $past(ack_i));
    a_r7_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o |=> $stable(data_o));
  end else begin : g_a2
    a_r5_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ack_o) |-> $past(req_i != ack_o));
    a_r2_req_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(req_o) |-> $past(req_o == ack_i));
    a_r7_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o != ack_i) |=> $stable(data_o));
  end
endmodule

bind mp_chain mp_chain_chk #(.DATA_W(DATA_W), .STAGES(STAGES), .MODE(MODE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .ack_o  (ack_o),
  .req_o  (req_o),
  .ack_i  (ack_i),
  .data_o (data_o)
);

// File: tb/mp_chain_tb.sv
module mp_chain_tb;
  localparam int N2 = 4, D2 = 2;
  localparam int N4 = 3, D4 = 1;
  localparam int NSEQ = 56;
  // {data[11:4], stall[3:0]}
  localparam logic [11:0] VEC [16] = '{
    12'h010, 12'h022, 12'h0F0, 12'hFF5, 12'h5A1, 12'hA53, 12'h000, 12'h7E4,
    12'h810, 12'h3C2, 12'hC30, 12'h661, 12'h995, 12'h123, 12'hFE0, 12'h0B4};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, ack_i = 0, ack_o, req_o;
  logic [7:0] data_i = '0, data_o;
  logic r4_req = 0, r4_acki = 0, r4_acko, r4_reqo;
  logic [7:0] r4_din = '0, r4_dout;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mp_chain #(.DATA_W(8), .STAGES(N2), .MATCH_DLY(D2), .MODE(mp_pkg::HS_TWO_PHASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .ack_o(ack_o), .data_i(data_i),
    .req_o(req_o), .ack_i(ack_i), .data_o(data_o));

  mp_chain #(.DATA_W(8), .STAGES(N4), .MATCH_DLY(D4), .MODE(mp_pkg::HS_FOUR_PHASE)) u_dut_4p (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(r4_req), .ack_o(r4_acko), .data_i(r4_din),
    .req_o(r4_reqo), .ack_i(r4_acki), .data_o(r4_dout));

  task automatic chk(input string rq, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_nx(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic push2(input logic [7:0] d);
    data_i = d;
    req_i  = ~req_i;
    while (ack_o != req_i) @(negedge clk);
  endtask

  task automatic try_push2(input logic [7:0] d, output bit ok);
    int t = 0;
    data_i = d;
    req_i  = ~req_i;
    while (ack_o != req_i && t < 40) begin @(negedge clk); t++; end
    ok = (ack_o == req_i);
  endtask

  task automatic pop2(input logic [7:0] exp, input int stall, input string rq);
    while (req_o == ack_i) @(negedge clk);
    chk(rq, int'(data_o), int'(exp));
    repeat (stall) @(negedge clk);
    ack_i = ~ack_i;
  endtask

  task automatic push4(input logic [7:0] d);
    r4_din = d;
    r4_req = 1'b1;
    while (!r4_acko) @(negedge clk);
    r4_req = 1'b0;
    while (r4_acko) @(negedge clk);
  endtask

  task automatic pop4(input logic [7:0] exp, input int hold);
    while (!r4_reqo) @(negedge clk);
    chk("R4 four-phase order", int'(r4_dout), int'(exp));
    r4_acki = 1'b1;
    @(negedge clk);
    chk("R9 req_o drops after ack_i", int'(r4_reqo), 0);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk("R9 req_o low while ack_i high", int'(r4_reqo), 0);
    end
    r4_acki = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] seq [NSEQ];
    int stl [NSEQ];
    logic [15:0] lf;
    int in_cnt, out_cnt, occ_max, t, ta, acc;
    bit ok;

    // R1 reset state
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 req_o after reset", int'(req_o), 0);
    chk("R1 ack_o after reset", int'(ack_o), 0);
    chk("R1 4p req_o after reset", int'(r4_reqo), 0);
    chk("R1 4p ack_o after reset", int'(r4_acko), 0);

    // R6 single-token latency
    data_i = 8'hA5;
    req_i  = ~req_i;
    t = 0; ta = -1;
    while (req_o == ack_i && t < 100) begin
      @(negedge clk); t++;
      if (ack_o == req_i && ta < 0) ta = t;
    end
    chk("R6 ack_o latency", ta, D2 + 1);
    chk("R6 req_o latency", t, N2 * (D2 + 1));
    chk("R4 first item data", int'(data_o), 8'hA5);
    ack_i = ~ack_i;
    repeat (5) @(negedge clk);

    // vector table then pseudo-random items, random stalls (R4, R5, R11)
    lf = 16'hACE1;
    for (int k = 0; k < NSEQ; k++) begin
      if (k < 16) begin
        seq[k] = VEC[k][11:4];
        stl[k] = int'(VEC[k][3:0]);
      end else begin
        lf = lfsr_nx(lf); seq[k] = lf[7:0];
        lf = lfsr_nx(lf); stl[k] = int'(lf[2:0]);
      end
    end
    in_cnt = 0; out_cnt = 0; occ_max = 0;
    fork
      for (int k = 0; k < NSEQ; k++) begin
        push2(seq[k]);
        in_cnt++;
        if (in_cnt - out_cnt > occ_max) occ_max = in_cnt - out_cnt;
      end
      for (int k = 0; k < NSEQ; k++) begin
        pop2(seq[k], stl[k], "R4 R5 sequence order");
        out_cnt++;
      end
    join
    chk("R11 max occupancy bound", int'(occ_max <= N2), 1);
    chk("R5 items in equals items out", in_cnt, out_cnt);
    repeat (30) @(negedge clk);
    chk("R4 no duplicate after drain", int'(req_o == ack_i), 1);

    // R3 capacity with stalled output
    acc = 0;
    for (int k = 0; k <= N2; k++) begin
      try_push2(8'h30 + 8'(k), ok);
      if (ok) acc++;
    end
    chk("R3 items accepted when stalled", acc, N2);
    repeat (10) @(negedge clk);
    chk("R3 extra request unacknowledged", int'(ack_o == req_i), 0);
    chk("R7 pending output held", int'(req_o != ack_i), 1);
    chk("R7 head data held", int'(data_o), 8'h30);
    for (int k = 0; k <= N2; k++) pop2(8'h30 + 8'(k), 1, "R3 drain order");
    repeat (10) @(negedge clk);
    chk("R3 extra request accepted after room", int'(ack_o == req_i), 1);
    chk("R2 no request after drain", int'(req_o == ack_i), 1);

    // R1 reset with tokens inside
    try_push2(8'h11, ok);
    try_push2(8'h22, ok);
    rst_ni = 1'b0; req_i = 1'b0; ack_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 req_o after mid-run reset", int'(req_o), 0);
    chk("R1 ack_o after mid-run reset", int'(ack_o), 0);
    repeat (20) @(negedge clk);
    chk("R1 chain empty after reset", int'(req_o == ack_i), 1);
    try_push2(8'h77, ok);
    pop2(8'h77, 0, "R1 first item after reset");

    // four-phase latency (R8, R10)
    @(negedge clk);
    r4_din = 8'h5C;
    r4_req = 1'b1;
    t = 0; ta = -1;
    while (!r4_reqo && t < 100) begin
      @(negedge clk); t++;
      if (r4_acko && ta < 0) ta = t;
    end
    chk("R8 ack_o rise latency", ta, D4 + 3);
    chk("R10 req_o rise latency", t, N4 * (D4 + 1) + 2);
    chk("R7 4p data at req_o", int'(r4_dout), 8'h5C);
    r4_req = 1'b0;
    @(negedge clk);
    chk("R8 ack_o falls after req_i", int'(r4_acko), 0);
    pop4(8'h5C, 3);

    // four-phase stream with held acknowledges (R4, R9)
    fork
      for (int k = 0; k < 8; k++) push4(8'hC0 + 8'(k));
      for (int k = 0; k < 8; k++) pop4(8'hC0 + 8'(k), k % 3);
    join
    repeat (20) @(negedge clk);
    chk("R4 4p no duplicate", int'(r4_reqo), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule